// File: doc/BRIEF.md
# Coded Mark Inversion Line Encoder

This block turns a serial stream of data bits into a two-level Coded Mark Inversion line signal. Each bit period is split into two halves, and a single-cycle half-bit enable from the surrounding logic marks each half. The line output changes only on a clock edge where that enable is high. A data 0 goes out as a low half followed by a high half, so every 0 has a rising edge at mid-bit. A data 1 holds one level for the whole period, and successive 1s alternate in level.

Data enters through a valid/ready handshake. Ready is raised only in the enabled cycle that begins a new bit period, so exactly one bit is taken per period. If no bit is offered at that boundary, the encoder sends a 0 and keeps its stored polarity. The stored polarity is the level used by the most recent 1. It is cleared by reset, so the first 1 after reset goes out high.

Top module: `cmi_line_encoder`

## Requirements
- R1: While reset (rst_n low) is held, line_out is 0 and in_ready is 0 whenever half_en is 0.
- R2: A data 0 is sent as line_out = 0 for the first half-bit and line_out = 1 for the second half-bit.
- R3: A data 1 holds line_out at a single level for both halves of its bit period.
- R4: Each data 1 uses the level opposite to the previous data 1, however many 0s or idle periods lie between them.
- R5: The first data 1 after reset is sent at the high level (line_out = 1).
- R6: When in_valid is 0 at a bit boundary, the encoder sends the 0 pattern and the polarity state is left unchanged, so in_data has no effect in that period.
- R7: line_out changes only on a rising clock edge where half_en is 1.
- R8: in_ready is 1 only in a cycle where half_en is 1 and that enable starts a new bit period (the first half). It is 0 for mid-bit enables and in all other cycles.
- R9: line_out never falls from 1 to 0 at mid-bit. A falling edge appears only at the start of a bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_en | input | 1 | Single-cycle enable, one pulse per half-bit |
| in_valid | input | 1 | A data bit is offered |
| in_data | input | 1 | The offered data bit |
| in_ready | output | 1 | The offered bit is taken in this cycle |
| line_out | output | 1 | Coded line level |

## Verification
The stimulus includes runs of 0s, runs of 1s and alternating bits. Runs of 0s show that the low-then-high half order is fixed. Runs of 1s show that the level flips from each 1 to the next. Alternating bits show that a 1 still flips its level when 0s lie between successive 1s. Idle boundaries are driven with in_data set to 1, to show that an unoffered bit neither changes the line pattern nor moves the polarity. The gap between half-bit enables is varied, to show that the output holds between enables and that ready appears only on the enables that start a bit period.

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  input  logic in_valid,
  input  logic in_data,
  output logic in_ready,
  output logic line_out
);

  logic second_half;
  logic pol_q;
  logic mark_q;
  logic take;
  logic bit_now;

  assign in_ready = half_en & ~second_half;
  assign take     = in_ready & in_valid;
  assign bit_now  = take & in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      pol_q       <= 1'b0;
      mark_q      <= 1'b0;
      line_out    <= 1'b0;
    end else if (half_en) begin
      second_half <= ~second_half;
      if (!second_half) begin
        mark_q <= bit_now;
        if (bit_now) begin
          pol_q    <= ~pol_q;
          line_out <= ~pol_q;
        end else begin
          line_out <= 1'b0;
        end
      end else if (!mark_q) begin
        line_out <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmi_line_encoder_chk.sv
module cmi_line_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic in_ready,
  input logic line_out,
  input logic second_half,
  input logic mark_q
);

  a_r7_hold_between_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_out));

  a_r8_ready_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (half_en && !second_half));

  a_r9_no_mid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_out) |-> second_half);

  a_r2_zero_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && second_half && !mark_q) |=> line_out);

  a_r3_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && second_half && mark_q) |=> $stable(line_out));

endmodule

bind cmi_line_encoder cmi_line_encoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_ready(in_ready),
  .line_out(line_out), .second_half(second_half), .mark_q(mark_q)
);

// File: tb/cmi_line_encoder_tb_top.sv
module cmi_line_encoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_data = 1'b0;
  logic in_ready;
  logic line_out;

  int checks = 0;
  int errors = 0;
  logic exp_q[$];
  string tag_q[$];
  logic model_pol = 1'b0;
  logic seen_one = 1'b0;
  logic last_exp = 1'b0;
  logic pend = 1'b0;
  logic running = 1'b0;

  always #10 clk = ~clk;

  cmi_line_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .line_out(line_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_gap(input int gap, input logic v, input logic d);
    for (int i = 0; i < gap; i++) begin
      @(posedge clk); #2;
      half_en = 1'b0; in_valid = v; in_data = d;
      #1 check("R8 idle ready", in_ready, 1'b0);
    end
  endtask

  task automatic send_bit(input logic v, input logic d, input int gap);
    logic b;
    b = v & d;
    if (b) begin
      model_pol = ~model_pol;
      exp_q.push_back(model_pol); exp_q.push_back(model_pol);
      tag_q.push_back(seen_one ? "R4" : "R5"); tag_q.push_back("R3");
      seen_one = 1'b1;
    end else begin
      exp_q.push_back(1'b0); exp_q.push_back(1'b1);
      tag_q.push_back(v ? "R2" : "R6"); tag_q.push_back(v ? "R2" : "R6");
    end
    idle_gap(gap, v, d);
    @(posedge clk); #2;
    half_en = 1'b1; in_valid = v; in_data = d;
    #1 check("R8 boundary ready", in_ready, 1'b1);
    idle_gap(gap, v, d);
    @(posedge clk); #2;
    half_en = 1'b1;
    #1 check("R8 mid ready", in_ready, 1'b0);
    @(posedge clk); #2;
    half_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (pend) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R7 actual=%0b expected=<none>", line_out);
        end else begin
          last_exp = exp_q.pop_front();
          check(tag_q.pop_front(), line_out, last_exp);
        end
      end else begin
        check("R7 hold", line_out, last_exp);
      end
      pend = half_en;
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #8;
    check("R1 line", line_out, 1'b0);
    check("R1 ready", in_ready, 1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    running = 1'b1;
    send_bit(1'b1, 1'b0, 0);
    send_bit(1'b1, 1'b0, 2);
    send_bit(1'b1, 1'b1, 1);
    send_bit(1'b1, 1'b1, 0);
    send_bit(1'b1, 1'b1, 3);
    send_bit(1'b0, 1'b1, 1);
    send_bit(1'b0, 1'b1, 0);
    send_bit(1'b1, 1'b1, 2);
    for (int k = 0; k < 6; k++) send_bit(1'b1, k[0], k % 3);
    send_bit(1'b1, 1'b0, 1);
    send_bit(1'b1, 1'b0, 0);
    send_bit(1'b1, 1'b1, 1);
    send_bit(1'b0, 1'b0, 2);
    send_bit(1'b1, 1'b1, 0);
    idle_gap(4, 1'b0, 1'b0);
    check("R7 queue drained", exp_q.size() == 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule